// File: doc/BRIEF.md
# Multiplexed Video Clock Generator

This block derives the control clocks of a multiplexed pixel output stage from one pixel-rate clock. A load strobe runs at the pixel rate divided by the current multiplex factor M. The strobe latches a group of pixels that arrive in parallel into the serializer. A second clock, the programmable clock, runs at the pixel rate divided by a separately chosen factor N. It can serve as a master clock for the graphics controller, and its rising edges are kept in phase with the load strobe. A third output is the video memory shift clock. It is the external shift clock ANDed with the active-video qualifier and registered on the pixel clock, so memory shifting stops during blanking.

Both dividers are driven from one shared phase counter. The counter counts up to the larger of M and N and then wraps. Whenever it reaches zero, both outputs start their high phase together. A change to either divide field is held until the current load-strobe period has ended. At that point the new ratios are loaded and the counter restarts at zero, so the two outputs stay aligned across the change.

Top module: `mux_video_clkgen`

## Requirements
- R1: While `rst_n` is low, `load_strobe` and `prog_clk` are low at every clock edge. On the first clock edge after `rst_n` goes high, both outputs go high.
- R2: `mux_rate` selects the load-strobe period M in pixel clocks: code 2'b00 gives 8, 2'b01 gives 4, 2'b10 gives 2 and 2'b11 gives 8. Counting from the first edge after reset, the strobe is high for the first M/2 cycles of each period and low for the remaining M/2.
- R3: `div_sel` selects the programmable clock period N: code 2'b00 gives 4, 2'b01 gives 8, 2'b10 gives 16 and 2'b11 gives 32. The clock is high for the first N/2 cycles of each period and low for the remaining N/2.
- R4: When N is at least M, every rising edge of `prog_clk` happens on the same clock edge as a rising edge of `load_strobe`.
- R5: When N is less than M, `prog_clk` is high in every cycle in which `load_strobe` rises, and both outputs start each load period together.
- R6: A change to `mux_rate` or `div_sel` has no effect before the current load-strobe period ends. On the edge after that period's last cycle, both outputs restart at the beginning of the new ratios and both go high.
- R7: `sck_mem` equals `sck_ext AND vid_active` as sampled at the previous rising edge of `clk_pix`.
- R8: While `vid_active` is low (blanking), `sck_mem` is low one cycle later, whatever `sck_ext` does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_pix | input | 1 | Pixel-rate clock |
| rst_n | input | 1 | Synchronous active-low reset; divide fields are sampled while it is low |
| mux_rate | input | 2 | Multiplex-rate field that selects M |
| div_sel | input | SEL_W (2) | Divide-select field that selects N |
| sck_ext | input | 1 | External video memory shift clock |
| vid_active | input | 1 | High during active video, low during blanking |
| load_strobe | output | 1 | Pixel-group load strobe, pixel clock divided by M |
| prog_clk | output | 1 | Programmable clock, pixel clock divided by N |
| sck_mem | output | 1 | Blank-gated, registered shift clock |

## Verification
All three outputs come from one register stage. The strobe and the programmable clock therefore show the value for counter position i on the edge that loads that position, and `sck_mem` follows its inputs after exactly one edge. Reset is released on a falling edge. Sample number zero is taken on the falling edge that follows the first rising edge after release, and sample i is compared with the value expected at counter position i. For a field change made after sample k, the bench works out the first index past k that is a multiple of the old M. It uses the new ratios from that index on and the old ratios before it. Shift-clock stimulus is applied on one falling edge and checked on the next.

// File: rtl/vclk_pkg.sv
package vclk_pkg;

   localparam int MUX_CODE_W  = 2;
   localparam int MUX_MAX_LOG = 3;

   // log2 of the multiplex factor; the unused code falls back to 8:1
   function automatic int unsigned mux_code_log(input logic [MUX_CODE_W-1:0] code);
      case (code)
         2'b01:   return 2;
         2'b10:   return 1;
         default: return MUX_MAX_LOG;
      endcase
   endfunction

endpackage

// File: rtl/vclk_ratio_dec.sv
module vclk_ratio_dec
   import vclk_pkg::*;
#(
   parameter int LOG_W       = 3,
   parameter int DIV_MIN_LOG = 2,
   parameter int SEL_W       = 2
) (
   input  logic [MUX_CODE_W-1:0] mux_code,
   input  logic [SEL_W-1:0]      sel_code,
   output logic [LOG_W-1:0]      m_log,
   output logic [LOG_W-1:0]      n_log
);

   always_comb begin
      m_log = LOG_W'(mux_code_log(mux_code));
      n_log = LOG_W'(DIV_MIN_LOG) + LOG_W'(sel_code);
   end

endmodule

// File: rtl/vclk_phase_ctr.sv
module vclk_phase_ctr #(
   parameter int CNT_W = 5,
   parameter int LOG_W = 3
) (
   input  logic             clk_pix,
   input  logic             rst_n,
   input  logic [LOG_W-1:0] req_m_log,
   input  logic [LOG_W-1:0] req_n_log,
   output logic [CNT_W-1:0] cnt_nxt,
   output logic [LOG_W-1:0] m_log_nxt,
   output logic [LOG_W-1:0] n_log_nxt,
   output logic [LOG_W-1:0] act_m_log,
   output logic [LOG_W-1:0] act_n_log
);

   localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

   logic [CNT_W-1:0] cnt_q;
   logic [LOG_W-1:0] span_log;
   logic [CNT_W-1:0] span_mask;
   logic [CNT_W-1:0] strobe_mask;
   logic             strobe_last;
   logic             fields_moved;

   always_comb begin
      span_log     = (act_m_log > act_n_log) ? act_m_log : act_n_log;
      span_mask    = ~(ALL_ONES << span_log);
      strobe_mask  = ~(ALL_ONES << act_m_log);
      strobe_last  = (cnt_q & strobe_mask) == strobe_mask;
      fields_moved = (req_m_log != act_m_log) || (req_n_log != act_n_log);
      if (strobe_last && fields_moved) begin
         cnt_nxt   = '0;
         m_log_nxt = req_m_log;
         n_log_nxt = req_n_log;
      end else begin
         cnt_nxt   = (cnt_q + CNT_W'(1)) & span_mask;
         m_log_nxt = act_m_log;
         n_log_nxt = act_n_log;
      end
   end

   always_ff @(posedge clk_pix) begin
      if (!rst_n) begin
         cnt_q     <= ALL_ONES;
         act_m_log <= req_m_log;
         act_n_log <= req_n_log;
      end else begin
         cnt_q     <= cnt_nxt;
         act_m_log <= m_log_nxt;
         act_n_log <= n_log_nxt;
      end
   end

   // ratios may only switch on the edge that follows the last cycle of a strobe period
   assert_ratio_switch_on_boundary_R6: assert property (@(posedge clk_pix)
      disable iff (!rst_n)
      ($past(rst_n) && ((act_m_log != $past(act_m_log)) || (act_n_log != $past(act_n_log))))
         |-> $past(strobe_last));

   // the counter restarts from zero whenever the ratios switch
   assert_restart_on_switch_R6: assert property (@(posedge clk_pix)
      disable iff (!rst_n)
      ($past(rst_n) && (act_m_log != $past(act_m_log))) |-> (cnt_q == '0));

endmodule

// File: rtl/vclk_half_flop.sv
module vclk_half_flop #(
   parameter int CNT_W = 5,
   parameter int LOG_W = 3
) (
   input  logic             clk_pix,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] cnt_nxt,
   input  logic [LOG_W-1:0] log_nxt,
   output logic             q
);

   logic half_bit;

   // the bit that marks the second half of a 2**log_nxt period
   always_comb begin
      half_bit = 1'b0;
      for (int b = 0; b < CNT_W; b++) begin
         if (int'(log_nxt) == b + 1) half_bit = cnt_nxt[b];
      end
   end

   always_ff @(posedge clk_pix) begin
      if (!rst_n) q <= 1'b0;
      else        q <= ~half_bit;
   end

endmodule

// File: rtl/vclk_sck_gate.sv
module vclk_sck_gate (
   input  logic clk_pix,
   input  logic rst_n,
   input  logic sck_ext,
   input  logic vid_active,
   output logic sck_mem
);

   always_ff @(posedge clk_pix) begin
      if (!rst_n) sck_mem <= 1'b0;
      else        sck_mem <= sck_ext & vid_active;
   end

   assert_sck_follows_gate_R7: assert property (@(posedge clk_pix)
      disable iff (!rst_n)
      $past(rst_n) |-> (sck_mem == ($past(sck_ext) && $past(vid_active))));

   assert_sck_quiet_in_blank_R8: assert property (@(posedge clk_pix)
      disable iff (!rst_n)
      (rst_n && !vid_active) |=> !sck_mem);

endmodule

// File: rtl/mux_video_clkgen.sv
module mux_video_clkgen
   import vclk_pkg::*;
#(
   parameter int DIV_MIN_LOG = 2,
   parameter int SEL_W       = 2
) (
   input  logic                  clk_pix,
   input  logic                  rst_n,
   input  logic [MUX_CODE_W-1:0] mux_rate,
   input  logic [SEL_W-1:0]      div_sel,
   input  logic                  sck_ext,
   input  logic                  vid_active,
   output logic                  load_strobe,
   output logic                  prog_clk,
   output logic                  sck_mem
);

   localparam int CNT_W = DIV_MIN_LOG + (1 << SEL_W) - 1;
   localparam int LOG_W = $clog2(CNT_W + 1);
   localparam int NCH   = 2;

   if (DIV_MIN_LOG < 1 || SEL_W < 1) begin : g_bad_param
      $error("divider parameters out of range");
   end
   if (CNT_W < MUX_MAX_LOG) begin : g_bad_width
      $error("phase counter too narrow for the largest multiplex factor");
   end

   logic [LOG_W-1:0] req_m_log, req_n_log;
   logic [LOG_W-1:0] m_log_nxt, n_log_nxt;
   logic [LOG_W-1:0] act_m_log, act_n_log;
   logic [CNT_W-1:0] cnt_nxt;
   logic [LOG_W-1:0] ch_log [NCH];
   logic [NCH-1:0]   ch_q;

   vclk_ratio_dec #(
      .LOG_W(LOG_W), .DIV_MIN_LOG(DIV_MIN_LOG), .SEL_W(SEL_W)
   ) u_dec (
      .mux_code(mux_rate), .sel_code(div_sel),
      .m_log(req_m_log), .n_log(req_n_log)
   );

   vclk_phase_ctr #(
      .CNT_W(CNT_W), .LOG_W(LOG_W)
   ) u_ctr (
      .clk_pix(clk_pix), .rst_n(rst_n),
      .req_m_log(req_m_log), .req_n_log(req_n_log),
      .cnt_nxt(cnt_nxt), .m_log_nxt(m_log_nxt), .n_log_nxt(n_log_nxt),
      .act_m_log(act_m_log), .act_n_log(act_n_log)
   );

   assign ch_log[0] = m_log_nxt;
   assign ch_log[1] = n_log_nxt;

   for (genvar g = 0; g < NCH; g++) begin : g_chan
      vclk_half_flop #(
         .CNT_W(CNT_W), .LOG_W(LOG_W)
      ) u_flop (
         .clk_pix(clk_pix), .rst_n(rst_n),
         .cnt_nxt(cnt_nxt), .log_nxt(ch_log[g]), .q(ch_q[g])
      );
   end

   assign load_strobe = ch_q[0];
   assign prog_clk    = ch_q[1];

   vclk_sck_gate u_sck (
      .clk_pix(clk_pix), .rst_n(rst_n),
      .sck_ext(sck_ext), .vid_active(vid_active), .sck_mem(sck_mem)
   );

   assert_reset_quiet_R1: assert property (@(posedge clk_pix)
      !rst_n |=> (!load_strobe && !prog_clk));

   assert_prog_on_strobe_R4: assert property (@(posedge clk_pix)
      disable iff (!rst_n)
      ($rose(prog_clk) && (act_n_log >= act_m_log)) |-> $rose(load_strobe));

   assert_prog_high_at_strobe_R5: assert property (@(posedge clk_pix)
      disable iff (!rst_n)
      ($rose(load_strobe) && (act_n_log < act_m_log)) |-> prog_clk);

endmodule

// File: tb/mux_video_clkgen_tb_top.sv
`timescale 1ns/1ps
module mux_video_clkgen_tb_top;

   logic       clk_pix = 1'b0;
   logic       rst_n = 1'b0;
   logic [1:0] mux_rate = 2'b00;
   logic [1:0] div_sel = 2'b00;
   logic       sck_ext = 1'b0;
   logic       vid_active = 1'b0;
   logic       load_strobe, prog_clk, sck_mem;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #2.5 clk_pix = ~clk_pix;

   mux_video_clkgen dut_i (
      .clk_pix(clk_pix), .rst_n(rst_n), .mux_rate(mux_rate), .div_sel(div_sel),
      .sck_ext(sck_ext), .vid_active(vid_active),
      .load_strobe(load_strobe), .prog_clk(prog_clk), .sck_mem(sck_mem)
   );

   function automatic int m_of(input logic [1:0] c);
      case (c)
         2'b01:   return 4;
         2'b10:   return 2;
         default: return 8;
      endcase
   endfunction

   function automatic int n_of(input logic [1:0] c);
      return 4 << c;
   endfunction

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic do_reset(input logic [1:0] m, input logic [1:0] n);
      @(negedge clk_pix);
      rst_n = 1'b0;
      mux_rate = m;
      div_sel = n;
      repeat (3) @(negedge clk_pix);
      rst_n = 1'b1;
   endtask

   // R1: quiet outputs in reset, both high on the first edge after release
   task automatic t_reset();
      @(negedge clk_pix);
      rst_n = 1'b0;
      mux_rate = 2'b10;
      div_sel = 2'b00;
      repeat (3) @(negedge clk_pix);
      chk("R1", "load_strobe in reset", int'(load_strobe), 0);
      chk("R1", "prog_clk in reset", int'(prog_clk), 0);
      rst_n = 1'b1;
      @(negedge clk_pix);
      chk("R1", "load_strobe first cycle", int'(load_strobe), 1);
      chk("R1", "prog_clk first cycle", int'(prog_clk), 1);
      repeat (5) @(negedge clk_pix);
      rst_n = 1'b0;
      repeat (2) @(negedge clk_pix);
      chk("R1", "load_strobe mid-run reset", int'(load_strobe), 0);
      chk("R1", "prog_clk mid-run reset", int'(prog_clk), 0);
      rst_n = 1'b1;
   endtask

   // R2 R3 waveform shape, R4 R5 alignment, for one field combination
   task automatic t_ratio(input logic [1:0] m, input logic [1:0] n);
      int mm = m_of(m);
      int nn = n_of(n);
      int bad = 0;
      int bad_align = 0;
      logic pl = 1'b0;
      logic pp = 1'b0;
      do_reset(m, n);
      for (int i = 0; i < 72; i++) begin
         @(negedge clk_pix);
         if (load_strobe !== ((i % mm) < mm / 2)) bad++;
         if (prog_clk !== ((i % nn) < nn / 2)) bad++;
         if (nn >= mm && prog_clk && !pp && !(load_strobe && !pl)) bad_align++;
         if (nn < mm && load_strobe && !pl && !prog_clk) bad_align++;
         pl = load_strobe;
         pp = prog_clk;
      end
      chk("R2 R3", $sformatf("waveform mismatches mux=%0d sel=%0d", m, n), bad, 0);
      if (nn >= mm) chk("R4", $sformatf("unaligned prog rises mux=%0d sel=%0d", m, n), bad_align, 0);
      else          chk("R5", $sformatf("strobe rises without prog mux=%0d sel=%0d", m, n), bad_align, 0);
   endtask

   // R6: field change waits for the strobe boundary, then both restart
   task automatic t_change(input logic [1:0] m0, input logic [1:0] n0,
                           input logic [1:0] m1, input logic [1:0] n1, input int k);
      int mo = m_of(m0), no = n_of(n0), mn = m_of(m1), nw = n_of(n1);
      int b = (k / mo + 1) * mo;
      int bad = 0;
      do_reset(m0, n0);
      for (int i = 0; i < b + 64; i++) begin
         @(negedge clk_pix);
         if (i < b) begin
            if (load_strobe !== ((i % mo) < mo / 2)) bad++;
            if (prog_clk !== ((i % no) < no / 2)) bad++;
         end else begin
            if (load_strobe !== (((i - b) % mn) < mn / 2)) bad++;
            if (prog_clk !== (((i - b) % nw) < nw / 2)) bad++;
         end
         if (i == k) begin
            mux_rate = m1;
            div_sel = n1;
         end
      end
      chk("R6", $sformatf("change mismatches k=%0d boundary=%0d", k, b), bad, 0);
   endtask

   // R7 R8: registered gating of the shift clock
   task automatic t_shift();
      logic [1:0] pat [8] = '{2'b11, 2'b01, 2'b10, 2'b00, 2'b11, 2'b10, 2'b11, 2'b01};
      do_reset(2'b00, 2'b00);
      for (int i = 0; i < 8; i++) begin
         @(negedge clk_pix);
         sck_ext = pat[i][1];
         vid_active = pat[i][0];
         @(negedge clk_pix);
         if (!pat[i][0])
            chk("R8", $sformatf("sck_mem in blanking step %0d", i), int'(sck_mem), 0);
         else
            chk("R7", $sformatf("sck_mem step %0d", i), int'(sck_mem), int'(pat[i][1]));
      end
   endtask

   initial begin
      t_reset();
      for (int m = 0; m < 4; m++)
         for (int n = 0; n < 4; n++)
            t_ratio(2'(m), 2'(n));
      t_change(2'b00, 2'b01, 2'b10, 2'b10, 10);
      t_change(2'b10, 2'b11, 2'b00, 2'b00, 5);
      t_change(2'b01, 2'b00, 2'b11, 2'b11, 7);
      t_shift();
      if (!done) begin
         done = 1'b1;
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      #(200000 * 5);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
         $finish;
      end
   end

endmodule